// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block holds the decision logic that keeps a five-stage integer pipeline (fetch, decode, execute, memory, writeback) correct without software padding. Each cycle it looks at the register indices in the decode, execute, memory and writeback stages. From them it picks the source of each execute-stage operand. It holds fetch and decode for one cycle when a load is followed at once by an instruction that reads the loaded register. When execute resolves a taken branch or jump, it squashes the two younger instructions.

It also watches the request and response strobes of the instruction and data memory ports. While either port has a request outstanding with no response yet, every stage register is frozen. A port that answers in the cycle after its request costs no cycles, so straight-line code runs at one instruction per cycle.

The outputs are plain, per-cycle control levels. There is one load enable per stage register, a squash control for the fetch/decode register, a bubble control for the decode/execute register, and two operand selects. The datapath applies them at the next clock edge. No valid/ready handshake exists at this boundary. A request may be raised only in a cycle where `pc_en` is high or its port is not waiting. The block has no other back-pressure rule.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: After reset, with no memory request seen, all five stage enables are 1 and `ifid_flush`, `idex_bubble`, `fwd_a` and `fwd_b` are 0.
- R2: A port that had a request in cycle t is waiting in each later cycle up to, but not including, the first cycle its response strobe is 1. While either port waits, the pipeline is frozen.
- R3: While frozen, all five stage enables, `ifid_flush` and `idex_bubble` are 0.
- R4: A response in the cycle right after its request causes no frozen cycle, including back-to-back requests on both ports.
- R5: Operand select encoding: 2'b00 register file, 2'b01 writeback result, 2'b10 memory-stage result. The memory stage wins over writeback when both match the source register.
- R6: A source index of 0 always selects 2'b00, whatever the later stages hold.
- R7: A later stage is forwarded only when its write-enable is 1.
- R8: When not frozen and no redirect occurs, a load in execute with a nonzero destination equal to a used decode source (`id_use_rs1`/`id_use_rs2`) makes `pc_en`=0, `ifid_en`=0, `idex_en`=1, `exmem_en`=1, `memwb_en`=1, `idex_bubble`=1, `ifid_flush`=0.
- R9: An unused decode source, a non-load in execute, or destination 0 never causes the load-use hold.
- R10: When not frozen, `ex_redirect`=1 makes all enables 1 and both `ifid_flush` and `idex_bubble` 1, and this overrides a load-use condition.
- R11: A redirect or load-use condition present during a freeze takes effect in the first cycle the freeze releases, provided its inputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_req | input | 1 | Instruction port request issued this cycle |
| imem_resp | input | 1 | Instruction port response this cycle |
| dmem_req | input | 1 | Data port request issued this cycle |
| dmem_resp | input | 1 | Data port response this cycle |
| ex_rs1 | input | REG_AW | Execute-stage first source index |
| ex_rs2 | input | REG_AW | Execute-stage second source index |
| mem_rd | input | REG_AW | Memory-stage destination index |
| mem_wen | input | 1 | Memory-stage register write enable |
| wb_rd | input | REG_AW | Writeback-stage destination index |
| wb_wen | input | 1 | Writeback-stage register write enable |
| id_rs1 | input | REG_AW | Decode-stage first source index |
| id_rs2 | input | REG_AW | Decode-stage second source index |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rd | input | REG_AW | Execute-stage destination index |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_redirect | input | 1 | Execute resolved a taken branch or jump |
| pc_en | output | 1 | Program counter load enable |
| ifid_en | output | 1 | Fetch/decode register load enable |
| idex_en | output | 1 | Decode/execute register load enable |
| exmem_en | output | 1 | Execute/memory register load enable |
| memwb_en | output | 1 | Memory/writeback register load enable |
| ifid_flush | output | 1 | Load a bubble into fetch/decode |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| fwd_a | output | 2 | First operand select |
| fwd_b | output | 2 | Second operand select |

## Verification
The only state in the block is the per-port outstanding flag. A wrong flag shows at the ports in the very next cycle. A flag stuck high freezes the pipeline with no response pending, and a flag that is lost lets the enables rise while a port still waits. The remaining outputs depend only on the current cycle's inputs. So a wrong priority, a missed x0 guard or a mishandled use flag shows in the same cycle as the offending input combination. The operand and load-use sweeps cover every index combination over a four-register space. This makes any such slip visible at once.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_port_track.sv
module hzd_port_track #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] resp,
  output logic [NPORT-1:0] waiting
);
  logic [NPORT-1:0] pend_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    // a request opens a transaction; the response closes it
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[p] <= 1'b0;
      else        pend_q[p] <= req[p] | (pend_q[p] & ~resp[p]);
    end
    assign waiting[p] = pend_q[p] & ~resp[p];
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]     rs,
  input  logic [AW-1:0]     mem_rd,
  input  logic              mem_wen,
  input  logic [AW-1:0]     wb_rd,
  input  logic              wb_wen,
  output hzd_pkg::fwd_sel_e sel
);
  import hzd_pkg::*;
  logic live, hit_mem, hit_wb;

  assign live    = (rs != '0);
  assign hit_mem = live & mem_wen & (mem_rd == rs);
  assign hit_wb  = live & wb_wen  & (wb_rd  == rs);

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [AW-1:0] src    [NSRC],
  input  logic          use_en [NSRC],
  input  logic [AW-1:0] ld_rd,
  input  logic          ld_valid,
  output logic          hit
);
  logic [NSRC-1:0] match;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign match[s] = use_en[s] & (src[s] == ld_rd);
  end

  assign hit = ld_valid & (ld_rd != '0) & (|match);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imem_req,
  input  logic              imem_resp,
  input  logic              dmem_req,
  input  logic              dmem_resp,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_load,
  input  logic              ex_redirect,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              idex_en,
  output logic              exmem_en,
  output logic              memwb_en,
  output logic              ifid_flush,
  output logic              idex_bubble,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);
  import hzd_pkg::*;
  localparam int NSRC  = 2;
  localparam int NPORT = 2;

  // memory ports -> global freeze
  logic [NPORT-1:0] port_req, port_resp, port_wait;
  logic             freeze;
  assign port_req  = {dmem_req,  imem_req};
  assign port_resp = {dmem_resp, imem_resp};

  hzd_port_track #(.NPORT(NPORT)) trk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (port_req),
    .resp    (port_resp),
    .waiting (port_wait)
  );
  assign freeze = |port_wait;

  // operand forwarding, one selector per execute source
  logic [REG_AW-1:0] ex_src [NSRC];
  fwd_sel_e          sel    [NSRC];
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    hzd_fwd_sel #(.AW(REG_AW)) fwd_i (
      .rs      (ex_src[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (sel[g])
    );
  end
  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  // load followed by dependent use
  logic [REG_AW-1:0] id_src [NSRC];
  logic              id_use [NSRC];
  logic              lu_hit;
  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;
  assign id_use[0] = id_use_rs1;
  assign id_use[1] = id_use_rs2;

  hzd_load_use #(.AW(REG_AW), .NSRC(NSRC)) lu_i (
    .src      (id_src),
    .use_en   (id_use),
    .ld_rd    (ex_rd),
    .ld_valid (ex_load),
    .hit      (lu_hit)
  );

  // arbitration: freeze > redirect > load-use > run
  always_comb begin
    pc_en       = 1'b1;
    ifid_en     = 1'b1;
    idex_en     = 1'b1;
    exmem_en    = 1'b1;
    memwb_en    = 1'b1;
    ifid_flush  = 1'b0;
    idex_bubble = 1'b0;
    if (freeze) begin
      pc_en    = 1'b0;
      ifid_en  = 1'b0;
      idex_en  = 1'b0;
      exmem_en = 1'b0;
      memwb_en = 1'b0;
    end else if (ex_redirect) begin
      ifid_flush  = 1'b1;
      idex_bubble = 1'b1;
    end else if (lu_hit) begin
      pc_en       = 1'b0;
      ifid_en     = 1'b0;
      idex_bubble = 1'b1;
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              imem_req,
  input logic              imem_resp,
  input logic              dmem_req,
  input logic              dmem_resp,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wen,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_wen,
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              id_use_rs1,
  input logic              id_use_rs2,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_load,
  input logic              ex_redirect,
  input logic              pc_en,
  input logic              ifid_en,
  input logic              idex_en,
  input logic              exmem_en,
  input logic              memwb_en,
  input logic              ifid_flush,
  input logic              idex_bubble,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b
);
  // R2: an unanswered instruction request freezes every stage
  a_r2_imem_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(imem_req) && !imem_resp) |-> (!pc_en && !memwb_en));

  // R2: an unanswered data request freezes every stage
  a_r2_dmem_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dmem_req) && !dmem_resp) |-> (!pc_en && !exmem_en));

  // R3: a frozen execute register comes with no squash or bubble
  a_r3_freeze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_en |-> (!ifid_flush && !idex_bubble && !pc_en));

  // R5: the operand select is never an unused code
  a_r5_sel_code: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(fwd_a) && $onehot0(fwd_b)));

  // R6: register zero reads the register file
  a_r6_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a == 2'b00));

  // R8: a held front end always injects a bubble behind it
  a_r8_hold_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_en && idex_en) |-> (idex_bubble && !ifid_flush && !ifid_en));

  // R10: a squash is always a redirect with both younger slots cleared
  a_r10_squash_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (idex_bubble && pc_en && ex_redirect));

  // R7: no forwarding from a stage that does not write
  a_r7_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && !wb_wen) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_AW(REG_AW)) chk_i (.*);

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic imem_req = 0, imem_resp = 0, dmem_req = 0, dmem_resp = 0;
  logic [AW-1:0] ex_rs1 = 0, ex_rs2 = 0, mem_rd = 0, wb_rd = 0;
  logic mem_wen = 0, wb_wen = 0;
  logic [AW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0;
  logic id_use_rs1 = 0, id_use_rs2 = 0, ex_load = 0, ex_redirect = 0;
  logic pc_en, ifid_en, idex_en, exmem_en, memwb_en, ifid_flush, idex_bubble;
  logic [1:0] fwd_a, fwd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_hazard_ctrl #(.REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_req(imem_req), .imem_resp(imem_resp),
    .dmem_req(dmem_req), .dmem_resp(dmem_resp),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .ex_rd(ex_rd), .ex_load(ex_load), .ex_redirect(ex_redirect),
    .pc_en(pc_en), .ifid_en(ifid_en), .idex_en(idex_en),
    .exmem_en(exmem_en), .memwb_en(memwb_en),
    .ifid_flush(ifid_flush), .idex_bubble(idex_bubble),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  function automatic logic [1:0] exp_fwd(int rs, int mrd, bit mw, int wrd, bit ww);
    if (rs == 0) return 2'b00;
    if (mw && mrd == rs) return 2'b10;
    if (ww && wrd == rs) return 2'b01;
    return 2'b00;
  endfunction

  // {pc, ifid, idex, exmem, memwb, flush, bubble}
  function automatic logic [6:0] exp_ctl(bit frz, bit redir, bit lu);
    if (frz)   return 7'b00000_00;
    if (redir) return 7'b11111_11;
    if (lu)    return 7'b00111_01;
    return 7'b11111_00;
  endfunction

  function automatic logic [6:0] got_ctl();
    return {pc_en, ifid_en, idex_en, exmem_en, memwb_en, ifid_flush, idex_bubble};
  endfunction

  task automatic check(string req, logic [10:0] got, logic [10:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic ctl_check(string req, bit frz, bit redir, bit lu);
    #1;
    check(req, {4'b0, got_ctl()}, {4'b0, exp_ctl(frz, redir, lu)});
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check("R1", {got_ctl(), fwd_a, fwd_b}, {7'b11111_00, 4'b0000});

    // R5 R6 R7: forwarding sweep over a four-register space
    for (int rs = 0; rs < 4; rs++)
      for (int mrd = 0; mrd < 4; mrd++)
        for (int wrd = 0; wrd < 4; wrd++)
          for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            ex_rs1 = AW'(rs); ex_rs2 = AW'(3 - rs);
            mem_rd = AW'(mrd); wb_rd = AW'(wrd);
            mem_wen = w[0]; wb_wen = w[1];
            #1;
            check("R5/R6/R7 fwd", {7'b0, fwd_a, fwd_b},
                  {7'b0, exp_fwd(rs, mrd, w[0], wrd, w[1]),
                         exp_fwd(3 - rs, mrd, w[0], wrd, w[1])});
          end
    mem_wen = 0; wb_wen = 0;

    // R8 R9 R10: load-use and redirect sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 4; d++)
          for (int f = 0; f < 16; f++) begin
            bit lu;
            @(negedge clk);
            id_rs1 = AW'(a); id_rs2 = AW'(b); ex_rd = AW'(d);
            id_use_rs1 = f[0]; id_use_rs2 = f[1];
            ex_load = f[2]; ex_redirect = f[3];
            lu = f[2] && d != 0 && ((f[0] && a == d) || (f[1] && b == d));
            ctl_check("R8/R9/R10 ctl", 1'b0, f[3], lu);
          end

    // R4: next-cycle answers on both ports, back to back
    @(negedge clk);
    id_use_rs1 = 0; id_use_rs2 = 0; ex_load = 0; ex_redirect = 0;
    imem_req = 1; dmem_req = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      imem_resp = 1; dmem_resp = 1;
      ctl_check("R4 next-cycle", 1'b0, 1'b0, 1'b0);
    end
    @(negedge clk);
    imem_req = 0; dmem_req = 0; imem_resp = 1; dmem_resp = 1;
    ctl_check("R4 last answer", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    imem_resp = 0; dmem_resp = 0;
    ctl_check("R4 idle", 1'b0, 1'b0, 1'b0);

    // R2 R3: instruction port waits three cycles
    @(negedge clk); imem_req = 1;
    ctl_check("R2 request cycle", 1'b0, 1'b0, 1'b0);
    @(negedge clk); imem_req = 0;
    for (int k = 0; k < 3; k++) begin
      ctl_check("R2/R3 imem wait", 1'b1, 1'b0, 1'b0);
      @(negedge clk);
    end
    imem_resp = 1;
    ctl_check("R2 imem release", 1'b0, 1'b0, 1'b0);
    @(negedge clk); imem_resp = 0;
    ctl_check("R2 after release", 1'b0, 1'b0, 1'b0);

    // R2: both ports outstanding, instruction answers first
    @(negedge clk); imem_req = 1; dmem_req = 1;
    @(negedge clk); imem_req = 0; dmem_req = 0; imem_resp = 1;
    ctl_check("R2 data still waits", 1'b1, 1'b0, 1'b0);
    @(negedge clk); imem_resp = 0;
    ctl_check("R2 data waits alone", 1'b1, 1'b0, 1'b0);
    @(negedge clk); dmem_resp = 1;
    ctl_check("R2 data release", 1'b0, 1'b0, 1'b0);
    @(negedge clk); dmem_resp = 0;

    // R11: redirect held through a freeze
    dmem_req = 1;
    @(negedge clk); dmem_req = 0;
    ex_redirect = 1; ex_load = 1; ex_rd = 5'd2; id_rs1 = 5'd2; id_use_rs1 = 1;
    ctl_check("R11 redirect frozen", 1'b1, 1'b1, 1'b1);
    @(negedge clk); dmem_resp = 1;
    ctl_check("R11 redirect on release", 1'b0, 1'b1, 1'b1);
    @(negedge clk); dmem_resp = 0; ex_redirect = 0;

    // R11: load-use held through a freeze
    imem_req = 1;
    @(negedge clk); imem_req = 0;
    ctl_check("R11 load-use frozen", 1'b1, 1'b0, 1'b1);
    @(negedge clk); imem_resp = 1;
    ctl_check("R11 load-use on release", 1'b0, 1'b0, 1'b1);
    @(negedge clk); imem_resp = 0; ex_load = 0;
    ctl_check("R8 bubble leaves", 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule